// File: doc/BRIEF.md
# Region Protection Address Translator

This block translates and checks addresses for a processor core that has no paging unit. The 32-bit address space is cut into eight equal regions of 512 MB, chosen by the three most significant address bits. Each region holds a 3-bit physical base (the top three bits of the physical address) and a 4-bit attribute code. For each request the block returns the physical address, the page size as a power of two, the granted rights, a cache policy and a fault cause. Requests carry a kind: read, write or instruction fetch. A fault is raised when the right that kind needs is missing.

A static mode pin selects a pass-through variant for cores without a region table. In that mode the address is returned unchanged. The attribute code comes from a 32-bit cache-attribute input that holds one 4-bit field per region. Region entries are loaded through a synchronous write port. Reset gives every region an identity mapping with attribute code 2.

Requests enter on a valid/ready pair and results leave on a second valid/ready pair through a single output register. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its result is presented in the next cycle and stays unchanged until `rsp_ready` is seen high. `req_ready` is low only while a result is held and `rsp_ready` is low, so a full pipeline moves one request per cycle.

Top module: `rgn_xlate`

## Requirements
- R1: In region mode (`bypass_mode`=0), the region index is `req_addr[31:29]`. A request that does not fault returns `rsp_paddr` = {region base, `req_addr[28:0]`}. `rsp_page_log2` is 29 for every region-mode result.
- R2: After reset, region i has base i and attribute code 2. Each region therefore maps to itself with read, write and execute rights and the bypass cache policy.
- R3: Attribute decode. `rsp_rights` is {x,w,r}, bit 0 = read, bit 1 = write, bit 2 = execute. `rsp_cache` is 0 = bypass, 1 = write-through, 2 = write-back, 3 = isolate. The codes decode as follows:
  - code 0: read and write, write-through
  - code 1: read, write and execute, write-through
  - code 2: read, write and execute, bypass
  - code 3: execute only, write-back
  - code 4: read, write and execute, write-back
  - code 14: read and write, isolate
- R4: Code 5 gives read, write and execute with write-back in region mode, and no rights in pass-through mode. Codes 6 to 13 and 15 give no rights in either mode, with `rsp_cache` 0.
- R5: In pass-through mode (`bypass_mode`=1), the attribute code is `cache_attr[4*i+3:4*i]`, where i = `req_addr[31:29]`. A request that does not fault returns `rsp_paddr` = `req_addr`. `rsp_page_log2` is 12 for every pass-through result.
- R6: `req_kind` encodes the request type: 0 = read, 1 = write, 2 = fetch, 3 = read. Each kind needs one right: a read needs r, a write needs w, a fetch needs x. When that right is missing, `rsp_cause` reports the fault and `rsp_paddr` is 0. `rsp_cause` is 0 = none, 1 = load prohibited, 2 = store prohibited, 3 = fetch prohibited. `rsp_rights` and `rsp_cache` report the decoded code even when the request faults.
- R7: A request is accepted on an edge where `req_valid` and `req_ready` are high. `rsp_valid` rises in the next cycle. While `rsp_valid` is high and `rsp_ready` is low, all `rsp_*` outputs hold and `req_ready` is low.
- R8: A write with `wr_en` high replaces the base and attribute code of region `wr_idx` at the clock edge. A request accepted at that same edge still uses the old entry. Requests accepted at later edges use the new entry.
- R9: During and right after reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_mode | input | 1 | Static mode select: 1 = pass-through, 0 = region table |
| cache_attr | input | 32 | Per-region attribute codes used in pass-through mode |
| wr_en | input | 1 | Region entry write strobe |
| wr_idx | input | 3 | Region to write |
| wr_base | input | 3 | New physical base (top address bits) |
| wr_attr | input | 4 | New attribute code |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Virtual address |
| req_kind | input | 2 | Request kind (R6 encoding) |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_page_log2 | output | 5 | Log2 of page size |
| rsp_rights | output | 3 | Granted rights {x,w,r} |
| rsp_cache | output | 2 | Cache policy code |
| rsp_cause | output | 2 | Fault cause code |

## Verification
The vector table is applied first with a reprogrammed region table and then in pass-through mode with a packed attribute word.

- Every defined code and one undefined code are paired with each request kind. This separates a wrong rights decode from a wrong choice of fault cause.
- Code 5 appears in both modes, which shows whether the mode reaches the decoder.
- Regions get bases that differ from their index, which exposes a swapped base or offset field.
- Addresses sit at region edges, which exposes an off-by-one in the index bits.

Directed runs cover the reset identity map, a held result under back-pressure with a second request waiting, and a write that collides with a request at the same edge.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

  localparam int ATTR_W = 4;

  typedef enum logic [1:0] {
    KIND_READ   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_FETCH  = 2'd2,
    KIND_READ_B = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_LOAD  = 2'd1,
    CAUSE_STORE = 2'd2,
    CAUSE_FETCH = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    CACHE_BYPASS  = 2'd0,
    CACHE_WT      = 2'd1,
    CACHE_WB      = 2'd2,
    CACHE_ISOLATE = 2'd3
  } cache_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  typedef struct packed {
    rights_t rights;
    cache_e  cache;
  } perm_t;

  // Sparse code decode; the pass flag removes the extra write-back code.
  function automatic perm_t decode_attr(input logic [ATTR_W-1:0] code,
                                        input logic pass);
    perm_t p;
    p.rights = 3'b000;
    p.cache  = CACHE_BYPASS;
    case (code)
      4'd0:  begin p.rights = 3'b011; p.cache = CACHE_WT;      end
      4'd1:  begin p.rights = 3'b111; p.cache = CACHE_WT;      end
      4'd2:  begin p.rights = 3'b111; p.cache = CACHE_BYPASS;  end
      4'd3:  begin p.rights = 3'b100; p.cache = CACHE_WB;      end
      4'd4:  begin p.rights = 3'b111; p.cache = CACHE_WB;      end
      4'd5:  begin
        if (!pass) begin
          p.rights = 3'b111;
          p.cache  = CACHE_WB;
        end
      end
      4'd14: begin p.rights = 3'b011; p.cache = CACHE_ISOLATE; end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table #(
  parameter int IDX_W    = 3,
  parameter int ATTR_W   = 4,
  parameter int RST_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [ATTR_W-1:0] rd_attr
);

  localparam int N_RGN = 1 << IDX_W;

  logic [IDX_W-1:0]  base_all [N_RGN];
  logic [ATTR_W-1:0] attr_all [N_RGN];

  for (genvar g = 0; g < N_RGN; g++) begin : g_ent
    logic [IDX_W-1:0]  base_q;
    logic [ATTR_W-1:0] attr_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= IDX_W'(g);
        attr_q <= ATTR_W'(RST_ATTR);
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        base_q <= wr_base;
        attr_q <= wr_attr;
      end
    end

    assign base_all[g] = base_q;
    assign attr_all[g] = attr_q;
  end

  assign rd_base = base_all[rd_idx];
  assign rd_attr = attr_all[rd_idx];

endmodule

// File: rtl/rgn_rights.sv
module rgn_rights
  import rgn_pkg::*;
(
  input  logic [ATTR_W-1:0] code,
  input  logic              pass,
  input  kind_e             kind,
  output rights_t           rights,
  output cache_e            cache,
  output cause_e            cause
);

  perm_t perm;
  logic  granted;

  assign perm   = decode_attr(code, pass);
  assign rights = perm.rights;
  assign cache  = perm.cache;

  always_comb begin
    granted = 1'b0;
    cause   = CAUSE_NONE;
    case (kind)
      KIND_WRITE: begin
        granted = perm.rights.w;
        if (!granted) cause = CAUSE_STORE;
      end
      KIND_FETCH: begin
        granted = perm.rights.x;
        if (!granted) cause = CAUSE_FETCH;
      end
      default: begin
        granted = perm.rights.r;
        if (!granted) cause = CAUSE_LOAD;
      end
    endcase
  end

endmodule

// File: rtl/rgn_xlate.sv
module rgn_xlate
  import rgn_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IDX_W        = 3,
  parameter int PT_PAGE_LOG2 = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bypass_mode,
  input  logic [(ATTR_W<<IDX_W)-1:0]    cache_attr,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [IDX_W-1:0]              wr_base,
  input  logic [ATTR_W-1:0]             wr_attr,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [1:0]                    req_kind,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [ADDR_W-1:0]             rsp_paddr,
  output logic [$clog2(ADDR_W)-1:0]     rsp_page_log2,
  output logic [2:0]                    rsp_rights,
  output logic [1:0]                    rsp_cache,
  output logic [1:0]                    rsp_cause
);

  localparam int OFS_W  = ADDR_W - IDX_W;
  localparam int N_RGN  = 1 << IDX_W;
  localparam int PAGE_W = $clog2(ADDR_W);

  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  tbl_base;
  logic [ATTR_W-1:0] tbl_attr;
  logic [ATTR_W-1:0] ca_nib [N_RGN];
  logic [ATTR_W-1:0] code;
  logic [ADDR_W-1:0] paddr_c;
  logic [PAGE_W-1:0] page_c;
  rights_t           rights_c;
  cache_e            cache_c;
  cause_e            cause_c;
  logic              accept;

  assign idx = req_addr[ADDR_W-1 -: IDX_W];

  rgn_table #(
    .IDX_W   (IDX_W),
    .ATTR_W  (ATTR_W),
    .RST_ATTR(2)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_base(wr_base),
    .wr_attr(wr_attr),
    .rd_idx (idx),
    .rd_base(tbl_base),
    .rd_attr(tbl_attr)
  );

  // Split the packed pass-through word into one code per region.
  for (genvar g = 0; g < N_RGN; g++) begin : g_nib
    assign ca_nib[g] = cache_attr[g*ATTR_W +: ATTR_W];
  end

  assign code = bypass_mode ? ca_nib[idx] : tbl_attr;

  rgn_rights u_rights (
    .code  (code),
    .pass  (bypass_mode),
    .kind  (kind_e'(req_kind)),
    .rights(rights_c),
    .cache (cache_c),
    .cause (cause_c)
  );

  always_comb begin
    if (cause_c != CAUSE_NONE) begin
      paddr_c = '0;
    end else if (bypass_mode) begin
      paddr_c = req_addr;
    end else begin
      paddr_c = {tbl_base, req_addr[OFS_W-1:0]};
    end
    page_c = bypass_mode ? PAGE_W'(PT_PAGE_LOG2) : PAGE_W'(OFS_W);
  end

  // Single output slot: the next request is taken when the slot is free or drains now.
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_page_log2 <= '0;
      rsp_rights    <= '0;
      rsp_cache     <= '0;
      rsp_cause     <= '0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_paddr     <= paddr_c;
      rsp_page_log2 <= page_c;
      rsp_rights    <= rights_c;
      rsp_cache     <= cache_c;
      rsp_cause     <= cause_c;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

endmodule

// File: rtl/rgn_xlate_chk.sv
module rgn_xlate_chk #(
  parameter int ADDR_W       = 32,
  parameter int IDX_W        = 3,
  parameter int PT_PAGE_LOG2 = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bypass_mode,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [ADDR_W-1:0]         rsp_paddr,
  input logic [$clog2(ADDR_W)-1:0] rsp_page_log2,
  input logic [2:0]                rsp_rights,
  input logic [1:0]                rsp_cache,
  input logic [1:0]                rsp_cause
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) &&
      $stable(rsp_rights) && $stable(rsp_cache) && $stable(rsp_cause) &&
      $stable(rsp_page_log2));

  assert_accept_gives_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_stall_blocks_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_fault_zero_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_cause != 2'd0) |-> (rsp_paddr == '0));

  assert_ok_has_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_cause == 2'd0) |-> ($countones(rsp_rights) > 0));

  assert_fetch_fault_no_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_cause == 2'd3) |-> !rsp_rights[2]);

  assert_region_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !bypass_mode |-> (rsp_page_log2 == ($clog2(ADDR_W))'(ADDR_W - IDX_W)));

  assert_pass_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && bypass_mode |-> (rsp_page_log2 == ($clog2(ADDR_W))'(PT_PAGE_LOG2)));

endmodule

bind rgn_xlate rgn_xlate_chk #(
  .ADDR_W      (ADDR_W),
  .IDX_W       (IDX_W),
  .PT_PAGE_LOG2(PT_PAGE_LOG2)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bypass_mode  (bypass_mode),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_paddr    (rsp_paddr),
  .rsp_page_log2(rsp_page_log2),
  .rsp_rights   (rsp_rights),
  .rsp_cache    (rsp_cache),
  .rsp_cause    (rsp_cause)
);

// File: tb/rgn_xlate_tb.sv
`timescale 1ns/1ps
module rgn_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass_mode = 1'b0;
  logic [31:0] cache_attr = 32'h2E54_3210;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [2:0]  wr_base = '0;
  logic [3:0]  wr_attr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [4:0]  rsp_page_log2;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_cache;
  logic [1:0]  rsp_cause;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rgn_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .bypass_mode(bypass_mode), .cache_attr(cache_attr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_attr(wr_attr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_page_log2(rsp_page_log2), .rsp_rights(rsp_rights), .rsp_cache(rsp_cache),
    .rsp_cause(rsp_cause)
  );

  typedef struct packed {
    logic        byp;
    logic [31:0] addr;
    logic [1:0]  kind;
    logic [31:0] paddr;
    logic [2:0]  rights;
    logic [1:0]  cache;
    logic [1:0]  cause;
  } vec_t;

  // Region table after programming: r0 b5 c0, r1 b1 c1, r2 b7 c3, r3 b0 c4,
  // r4 b2 c5, r5 b6 c14, r6 b6 c6, r7 reset. Pass-through word 0x2E543210.
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0123_4567, 2'd0, 32'hA123_4567, 3'b011, 2'd1, 2'd0}, // R1 R3 code 0
    '{1'b0, 32'h0000_0010, 2'd2, 32'h0000_0000, 3'b011, 2'd1, 2'd3}, // R6 fetch fault
    '{1'b0, 32'h3FFF_FFFC, 2'd1, 32'h3FFF_FFFC, 3'b111, 2'd1, 2'd0}, // R3 code 1
    '{1'b0, 32'h4000_0000, 2'd0, 32'h0000_0000, 3'b100, 2'd2, 2'd1}, // R3 code 3 load fault
    '{1'b0, 32'h5000_0004, 2'd2, 32'hF000_0004, 3'b100, 2'd2, 2'd0}, // R1 code 3 fetch ok
    '{1'b0, 32'h6ABC_DEF0, 2'd1, 32'h0ABC_DEF0, 3'b111, 2'd2, 2'd0}, // R3 code 4
    '{1'b0, 32'h8000_0100, 2'd2, 32'h4000_0100, 3'b111, 2'd2, 2'd0}, // R4 code 5 region
    '{1'b0, 32'hA000_0000, 2'd2, 32'h0000_0000, 3'b011, 2'd3, 2'd3}, // R3 code 14 fetch
    '{1'b0, 32'hBFFF_FFFF, 2'd1, 32'hDFFF_FFFF, 3'b011, 2'd3, 2'd0}, // R1 edge
    '{1'b0, 32'hC000_0000, 2'd0, 32'h0000_0000, 3'b000, 2'd0, 2'd1}, // R4 code 6 read
    '{1'b0, 32'hD000_0000, 2'd1, 32'h0000_0000, 3'b000, 2'd0, 2'd2}, // R6 store fault
    '{1'b0, 32'hE000_0008, 2'd3, 32'hE000_0008, 3'b111, 2'd0, 2'd0}, // R6 kind 3 = read
    '{1'b1, 32'h0000_1234, 2'd0, 32'h0000_1234, 3'b011, 2'd1, 2'd0}, // R5 nibble 0
    '{1'b1, 32'h6000_0000, 2'd1, 32'h0000_0000, 3'b100, 2'd2, 2'd2}, // R5 code 3 store
    '{1'b1, 32'h8765_4321, 2'd2, 32'h8765_4321, 3'b111, 2'd2, 2'd0}, // R5 code 4
    '{1'b1, 32'hA000_0040, 2'd0, 32'h0000_0000, 3'b000, 2'd0, 2'd1}, // R4 code 5 pass
    '{1'b1, 32'hC000_0000, 2'd1, 32'hC000_0000, 3'b011, 2'd3, 2'd0}, // R5 code 14
    '{1'b1, 32'hFFFF_FFF0, 2'd2, 32'hFFFF_FFF0, 3'b111, 2'd0, 2'd0}  // R5 top edge
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rsp(input string tag, input logic byp, input logic [31:0] paddr,
                         input logic [2:0] rights, input logic [1:0] cache,
                         input logic [1:0] cause);
    chk({tag, " valid"},  32'(rsp_valid), 32'd1);
    chk({tag, " paddr"},  rsp_paddr, paddr);
    chk({tag, " rights"}, 32'(rsp_rights), 32'(rights));
    chk({tag, " cache"},  32'(rsp_cache), 32'(cache));
    chk({tag, " cause"},  32'(rsp_cause), 32'(cause));
    chk({tag, " page"},   32'(rsp_page_log2), byp ? 32'd12 : 32'd29);
  endtask

  // Drive at a falling edge; the result is registered at the next rising edge.
  task automatic issue(input logic [31:0] addr, input logic [1:0] kind);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    req_kind  = kind;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] i, input logic [2:0] b, input logic [3:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_base = b; wr_attr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R9 req_ready after reset", 32'(req_ready), 32'd1);

    // R2: identity map, code 2
    issue(32'h9ABC_0000, 2'd1);
    chk_rsp("R2 reset r4", 1'b0, 32'h9ABC_0000, 3'b111, 2'd0, 2'd0);
    issue(32'h2000_0000, 2'd2);
    chk_rsp("R2 reset r1", 1'b0, 32'h2000_0000, 3'b111, 2'd0, 2'd0);

    // R8: program the table
    wr(3'd0, 3'd5, 4'd0);
    wr(3'd1, 3'd1, 4'd1);
    wr(3'd2, 3'd7, 4'd3);
    wr(3'd3, 3'd0, 4'd4);
    wr(3'd4, 3'd2, 4'd5);
    wr(3'd5, 3'd6, 4'd14);
    wr(3'd6, 3'd6, 4'd6);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].byp != bypass_mode) begin
        @(negedge clk);
        bypass_mode = VECS[k].byp;
      end
      issue(VECS[k].addr, VECS[k].kind);
      chk_rsp($sformatf("R1 R3 R4 R5 R6 vec %0d", k), VECS[k].byp, VECS[k].paddr,
              VECS[k].rights, VECS[k].cache, VECS[k].cause);
    end
    @(negedge clk);
    bypass_mode = 1'b0;

    // R7: back-pressure holds the result and blocks the next request
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h9ABC_0000; req_kind = 2'd0; rsp_ready = 1'b0;
    @(negedge clk);
    req_addr = 32'h0000_0000;
    chk("R7 ready low while held", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk_rsp("R7 held result", 1'b0, 32'h5ABC_0000, 3'b111, 2'd2, 2'd0);
    chk("R7 ready still low", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    #1;
    chk("R7 ready with consumer", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk_rsp("R7 second result", 1'b0, 32'hA000_0000, 3'b011, 2'd1, 2'd0);
    @(negedge clk);
    chk("R7 drained", 32'(rsp_valid), 32'd0);

    // R8: write and request at the same edge; request sees old entry
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd7; wr_base = 3'd0; wr_attr = 4'd6;
    req_valid = 1'b1; req_addr = 32'hE000_0010; req_kind = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk_rsp("R8 same edge old entry", 1'b0, 32'hE000_0010, 3'b111, 2'd0, 2'd0);
    issue(32'hE000_0010, 2'd0);
    chk_rsp("R8 later new entry", 1'b0, 32'h0000_0000, 3'b000, 2'd0, 2'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule